// File: doc/BRIEF.md
# Multi-Slot Tick Alarm Bank

This block keeps a fixed number of alarm slots, set when the block is built. Each slot has its own down-counter and stores a handler reference with an event-kind tag. Software arms a slot with a tick count, a handler reference, the kind of event to raise and an optional repeat flag. Software can also disarm a slot. Every pulse of a shared tick input decrements the counters of all armed slots.

When a counter runs out, the slot latches a pending flag. The interrupt line is asserted while any slot has its flag set. A registered report names the lowest-numbered pending slot, with its event kind and handler reference, so that the interrupt routine can dispatch the event. Software acknowledges the reported slot to clear its flag. The next pending slot, if any, is then reported. A repeating slot reloads its original count each time it fires. A one-shot slot goes idle after it fires.

Top module: `alarm_bank`

## Requirements
- R1: After reset no slot is armed or pending, `irq_o` is low and `rep_valid_o` is low.
- R2: A slot armed with count N raises its pending flag on the N-th tick after the arming cycle. `irq_o` goes high right after the clock edge that samples that tick. Cycles without `tick_i` do not advance a counter.
- R3: An arm request with a count of 0 is ignored. A slot that is already running keeps its current count.
- R4: One cycle after a slot becomes the lowest pending slot, `rep_valid_o` is high. In that cycle `rep_slot_o`, `rep_kind_o` and `rep_ref_o` hold that slot's index, event kind and handler reference. The kind codes are 0 = call a function, 1 = resume a thread and 2 = release a semaphore.
- R5: When several slots are pending, the lowest index is reported first. After it is acknowledged, the next pending slot is reported.
- R6: `irq_o` is high while at least one pending flag is set. An `ack_i` pulse clears only the flag of the slot shown by a valid report. An `ack_i` pulse while `rep_valid_o` is low is ignored. After an accepted acknowledge, `rep_valid_o` is low for one cycle.
- R7: A one-shot slot that has fired goes idle and does not fire again on later ticks.
- R8: A repeating slot reloads its armed count when it fires and fires again every N ticks.
- R9: Disarming a slot stops its counter and clears its pending flag, and it does not fire on later ticks.
- R10: Arming a slot that is already running restarts its count from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse of the shared time base |
| arm_i | input | 1 | Arm the slot given by `slot_i` |
| disarm_i | input | 1 | Disarm the slot given by `slot_i` (arm wins if both are set) |
| slot_i | input | IDX_W | Target slot index |
| count_i | input | CNT_W | Tick count loaded on arm |
| periodic_i | input | 1 | Repeat flag loaded on arm |
| kind_i | input | 2 | Event kind loaded on arm |
| ref_i | input | REF_W | Handler reference loaded on arm |
| ack_i | input | 1 | Acknowledge the reported slot |
| irq_o | output | 1 | High while any slot is pending |
| rep_valid_o | output | 1 | Report registers hold a pending slot |
| rep_slot_o | output | IDX_W | Index of the reported slot |
| rep_kind_o | output | 2 | Event kind of the reported slot |
| rep_ref_o | output | REF_W | Handler reference of the reported slot |

## Verification
The assertions assume three things about the inputs:
- `tick_i` is a single-cycle strobe.
- `slot_i` always addresses an existing slot when `arm_i` or `disarm_i` is high.
- Each acknowledge is a one-cycle pulse, given only after the report has been read.

The stimulus drives every request for exactly one cycle and uses only in-range slot numbers. It spaces acknowledges so that each one lands on a cycle where a report is valid, except for the one test that deliberately sends an acknowledge while no report is valid.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

   localparam int KIND_W = 2;

   typedef enum logic [KIND_W-1:0] {
      EV_CALL    = 2'd0,
      EV_RESUME  = 2'd1,
      EV_RELEASE = 2'd2,
      EV_RSVD    = 2'd3
   } ev_kind_e;

endpackage

// File: rtl/alarm_slot.sv
module alarm_slot
   import alarm_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int REF_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic                arm_hit_i,
   input  logic                disarm_hit_i,
   input  logic                ack_hit_i,
   input  logic [CNT_W-1:0]    load_i,
   input  logic                periodic_i,
   input  logic [KIND_W-1:0]   kind_i,
   input  logic [REF_W-1:0]    ref_i,
   output logic                pending_o,
   output logic [KIND_W-1:0]   kind_o,
   output logic [REF_W-1:0]    ref_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic              active_q;
   logic              periodic_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  period_q;
   ev_kind_e          kind_q;
   logic [REF_W-1:0]  ref_q;
   logic              pending_q;
   logic              fire;

   assign fire = active_q && tick_i && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         periodic_q <= 1'b0;
         cnt_q      <= '0;
         period_q   <= '0;
         kind_q     <= EV_CALL;
         ref_q      <= '0;
         pending_q  <= 1'b0;
      end else if (arm_hit_i) begin
         active_q   <= 1'b1;
         periodic_q <= periodic_i;
         cnt_q      <= load_i;
         period_q   <= load_i;
         kind_q     <= ev_kind_e'(kind_i);
         ref_q      <= ref_i;
         pending_q  <= 1'b0;
      end else if (disarm_hit_i) begin
         active_q   <= 1'b0;
         cnt_q      <= '0;
         pending_q  <= 1'b0;
      end else begin
         if (fire) begin
            pending_q <= 1'b1;
            if (periodic_q) begin
               cnt_q <= period_q;
            end else begin
               cnt_q    <= '0;
               active_q <= 1'b0;
            end
         end else begin
            if (active_q && tick_i) cnt_q <= cnt_q - ONE;
            if (ack_hit_i) pending_q <= 1'b0;
         end
      end
   end

   assign pending_o = pending_q;
   assign kind_o    = kind_q;
   assign ref_o     = ref_q;

   // R2
   live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (cnt_q != '0));

   // R2
   fire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending_q) |-> $past(tick_i));

   // R9
   disarm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disarm_hit_i && !arm_hit_i) |=> (!active_q && !pending_q));

   // R7
   idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !arm_hit_i) |=> (!active_q && $stable(cnt_q)));

endmodule

// File: rtl/alarm_pick.sv
module alarm_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      req_i,
   output logic              any_o,
   output logic [IDX_W-1:0]  idx_o
);

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end

   // R5
   pick_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> req_i[idx_o]);

endmodule

// File: rtl/alarm_bank.sv
module alarm_bank
   import alarm_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int CNT_W     = 16,
   parameter int REF_W     = 32,
   parameter int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               arm_i,
   input  logic               disarm_i,
   input  logic [IDX_W-1:0]   slot_i,
   input  logic [CNT_W-1:0]   count_i,
   input  logic               periodic_i,
   input  logic [1:0]         kind_i,
   input  logic [REF_W-1:0]   ref_i,
   input  logic               ack_i,
   output logic               irq_o,
   output logic               rep_valid_o,
   output logic [IDX_W-1:0]   rep_slot_o,
   output logic [1:0]         rep_kind_o,
   output logic [REF_W-1:0]   rep_ref_o
);

   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("alarm_bank: NUM_SLOTS must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("alarm_bank: CNT_W must be at least 2");
   end
   if (IDX_W < $clog2(NUM_SLOTS)) begin : g_bad_idx
      $error("alarm_bank: IDX_W too narrow for NUM_SLOTS");
   end

   logic [NUM_SLOTS-1:0]  pend_vec;
   logic [NUM_SLOTS-1:0]  pend_d;
   logic [KIND_W-1:0]     kind_arr [NUM_SLOTS];
   logic [REF_W-1:0]      ref_arr  [NUM_SLOTS];
   logic                  ack_ok;
   logic                  count_ok;
   logic                  pick_any;
   logic [IDX_W-1:0]      pick_idx;

   assign ack_ok   = ack_i && rep_valid_o;
   assign count_ok = (count_i != '0);

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic sel;
      assign sel = (slot_i == IDX_W'(g));

      alarm_slot #(
         .CNT_W (CNT_W),
         .REF_W (REF_W)
      ) u_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .tick_i       (tick_i),
         .arm_hit_i    (arm_i && sel && count_ok),
         .disarm_hit_i (disarm_i && sel),
         .ack_hit_i    (ack_ok && (rep_slot_o == IDX_W'(g))),
         .load_i       (count_i),
         .periodic_i   (periodic_i),
         .kind_i       (kind_i),
         .ref_i        (ref_i),
         .pending_o    (pend_vec[g]),
         .kind_o       (kind_arr[g]),
         .ref_o        (ref_arr[g])
      );
   end

   alarm_pick #(
      .N     (NUM_SLOTS),
      .IDX_W (IDX_W)
   ) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (pend_vec),
      .any_o (pick_any),
      .idx_o (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rep_valid_o <= 1'b0;
         rep_slot_o  <= '0;
         rep_kind_o  <= '0;
         rep_ref_o   <= '0;
         pend_d      <= '0;
      end else begin
         pend_d <= pend_vec;
         if (ack_ok) begin
            rep_valid_o <= 1'b0;
         end else begin
            rep_valid_o <= pick_any;
            rep_slot_o  <= pick_idx;
            rep_kind_o  <= kind_arr[pick_idx];
            rep_ref_o   <= ref_arr[pick_idx];
         end
      end
   end

   assign irq_o = |pend_vec;

   // R4
   report_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rep_valid_o |-> pend_d[rep_slot_o]);

   // R5
   report_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rep_valid_o |-> ((pend_d & ((NUM_SLOTS'(1) << rep_slot_o) - NUM_SLOTS'(1))) == '0));

   // R6
   ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && rep_valid_o) |=> !rep_valid_o);

endmodule

// File: tb/alarm_bank_tb.sv
module alarm_bank_tb;

   localparam int NS = 4;
   localparam int CW = 16;
   localparam int RW = 32;
   localparam int IW = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           tick_i = 1'b0;
   logic           arm_i = 1'b0;
   logic           disarm_i = 1'b0;
   logic [IW-1:0]  slot_i = '0;
   logic [CW-1:0]  count_i = '0;
   logic           periodic_i = 1'b0;
   logic [1:0]     kind_i = '0;
   logic [RW-1:0]  ref_i = '0;
   logic           ack_i = 1'b0;
   logic           irq_o;
   logic           rep_valid_o;
   logic [IW-1:0]  rep_slot_o;
   logic [1:0]     rep_kind_o;
   logic [RW-1:0]  rep_ref_o;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   alarm_bank #(.NUM_SLOTS(NS), .CNT_W(CW), .REF_W(RW), .IDX_W(IW)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .arm_i(arm_i),
      .disarm_i(disarm_i), .slot_i(slot_i), .count_i(count_i),
      .periodic_i(periodic_i), .kind_i(kind_i), .ref_i(ref_i),
      .ack_i(ack_i), .irq_o(irq_o), .rep_valid_o(rep_valid_o),
      .rep_slot_o(rep_slot_o), .rep_kind_o(rep_kind_o), .rep_ref_o(rep_ref_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick(input int n);
      repeat (n) begin
         tick_i = 1'b1;
         @(negedge clk);
         tick_i = 1'b0;
      end
   endtask

   task automatic arm(input int s, input int c, input logic per, input int k, input logic [RW-1:0] r);
      slot_i = IW'(s); count_i = CW'(c); periodic_i = per; kind_i = 2'(k); ref_i = r;
      arm_i = 1'b1;
      @(negedge clk);
      arm_i = 1'b0;
   endtask

   task automatic disarm(input int s);
      slot_i = IW'(s);
      disarm_i = 1'b1;
      @(negedge clk);
      disarm_i = 1'b0;
   endtask

   task automatic ack();
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 irq", 64'(irq_o), 64'd0);
      chk("R1 rep_valid", 64'(rep_valid_o), 64'd0);
   endtask

   task automatic t_oneshot();
      arm(1, 3, 1'b0, 1, 32'hCAFE_0001);
      tick(2);
      chk("R2 early", 64'(irq_o), 64'd0);
      cyc(3);
      chk("R2 no tick", 64'(irq_o), 64'd0);
      tick(1);
      chk("R2 fire", 64'(irq_o), 64'd1);
      cyc(1);
      chk("R4 valid", 64'(rep_valid_o), 64'd1);
      chk("R4 slot", 64'(rep_slot_o), 64'd1);
      chk("R4 kind", 64'(rep_kind_o), 64'd1);
      chk("R4 ref", 64'(rep_ref_o), 64'hCAFE_0001);
      ack();
      chk("R6 cleared irq", 64'(irq_o), 64'd0);
      chk("R6 gap", 64'(rep_valid_o), 64'd0);
      tick(5);
      chk("R7 no refire", 64'(irq_o), 64'd0);
   endtask

   task automatic t_zero();
      arm(0, 5, 1'b0, 0, 32'h0000_0A0A);
      tick(2);
      arm(0, 0, 1'b0, 2, 32'h0000_0B0B);
      tick(2);
      chk("R3 not reloaded", 64'(irq_o), 64'd0);
      tick(1);
      chk("R3 original count", 64'(irq_o), 64'd1);
      cyc(1);
      chk("R3 original ref", 64'(rep_ref_o), 64'h0000_0A0A);
      ack();
      cyc(1);
   endtask

   task automatic t_simul();
      arm(3, 2, 1'b0, 2, 32'h3333_0003);
      arm(2, 2, 1'b0, 0, 32'h2222_0002);
      tick(2);
      ack();
      chk("R6 early ack ignored", 64'(rep_valid_o), 64'd1);
      chk("R5 lowest first", 64'(rep_slot_o), 64'd2);
      chk("R4 kind call", 64'(rep_kind_o), 64'd0);
      ack();
      chk("R6 irq held", 64'(irq_o), 64'd1);
      cyc(1);
      chk("R5 next slot", 64'(rep_slot_o), 64'd3);
      chk("R4 kind release", 64'(rep_kind_o), 64'd2);
      chk("R4 ref next", 64'(rep_ref_o), 64'h3333_0003);
      ack();
      cyc(1);
      chk("R6 all clear", 64'(irq_o), 64'd0);
   endtask

   task automatic t_periodic();
      arm(0, 2, 1'b1, 1, 32'h0000_5050);
      tick(2);
      chk("R8 first", 64'(irq_o), 64'd1);
      cyc(1);
      ack();
      chk("R8 acked", 64'(irq_o), 64'd0);
      tick(1);
      chk("R8 between", 64'(irq_o), 64'd0);
      tick(1);
      chk("R8 second", 64'(irq_o), 64'd1);
      cyc(1);
      chk("R8 slot", 64'(rep_slot_o), 64'd0);
      disarm(0);
      chk("R9 pending cleared", 64'(irq_o), 64'd0);
      cyc(1);
      chk("R9 report drop", 64'(rep_valid_o), 64'd0);
      tick(4);
      chk("R9 stopped", 64'(irq_o), 64'd0);
   endtask

   task automatic t_rearm();
      arm(1, 4, 1'b0, 1, 32'h0000_1111);
      tick(3);
      arm(1, 4, 1'b0, 1, 32'h0000_2222);
      tick(3);
      chk("R10 restarted", 64'(irq_o), 64'd0);
      tick(1);
      chk("R10 fire", 64'(irq_o), 64'd1);
      cyc(1);
      chk("R10 new ref", 64'(rep_ref_o), 64'h0000_2222);
      ack();
      cyc(1);
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      cyc(3);
      t_reset();
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_oneshot();
      t_zero();
      t_simul();
      t_periodic();
      t_rearm();
      cyc(2);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule